// File: doc/BRIEF.md
# Serial Receiver with Status Flags and Read-Sequence Clearing

This block is the receive half of an asynchronous serial port. It watches a single serial input line and uses an external 16x oversampling tick to find start bits and sample each bit at its centre. It assembles frames with 8 or 9 data bits and keeps the latest character in a data register. A status register reports five event flags: character ready, overrun, idle line, noise and framing error. It also carries the ninth data bit.

Software clears the flags in two steps. A status read records which flags were set at that moment. The next data read clears exactly those flags and no others. If a character arrives between the two reads, the recorded set is discarded, so flags raised by that character cannot be lost. A single interrupt request is active while a character is waiting and its enable bit is set.

Register map: address 0 is control, address 1 is status (read only) and address 2 is data (read only). Address 3 reads as zero. Read data is combinational from the address. The side effects of a read take place at the clock edge while the read strobe is high.

Top module: `sci_rx_core`

## Requirements
- R1: After reset the control, status and data registers all read 0x00 and the interrupt output is low.
- R2: A frame is one low start bit, then the data bits least significant first, then one stop bit. The number of data bits is 9 when control bit 1 is set and 8 when it is clear. A completed frame loads the data register and sets status bit 0 (character ready).
- R3: In 9-bit mode the ninth data bit appears in status bit 5. In 8-bit mode status bit 5 reads 0 after a character. This bit is not a flag and the read sequence does not clear it.
- R4: If status bit 0 is already set when a frame completes, status bit 1 (overrun) is set and the data register takes the new character.
- R5: Each bit is sampled on ticks 7, 8 and 9 of its 16 ticks, and the majority value is used. If the three samples of any bit in a frame disagree, status bit 3 (noise) is set when that frame completes.
- R6: A stop bit whose majority value is 0 sets status bit 4 (framing error).
- R7: After a character, if the line stays high for one full frame time (10 bit times in 8-bit mode, 11 in 9-bit mode), status bit 2 (idle) is set. It is set once per received character.
- R8: A status read records which of status bits 0 to 4 are set. The next data read clears exactly the recorded bits.
- R9: A frame that completes after a status read discards the record, so the next data read clears nothing.
- R10: A data read with no record pending returns the character and leaves every flag unchanged.
- R11: Reception happens only while control bit 0 is set. While it is clear, activity on the line has no effect.
- R12: Writes to the status and data addresses have no effect.
- R13: The interrupt output is high exactly while status bit 0 and control bit 2 are both set.
- R14: A start edge that is not confirmed low by the mid-bit majority is treated as a false start, and no character is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line_i | input | 1 | Asynchronous serial input, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current address |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
Some internal faults show only later. A stale or wrongly cleared capture record shows at the next data read, where a flag either survives or disappears when it should not. A wrong sample counter or bit index shifts the data, so the very next character reads back corrupted. A wrong frame-length limit in the idle timer shifts the moment the idle flag rises by a whole bit time or more, and the bench looks for that flag only after a long wait. The overrun and false-start paths are visible at the status read that follows the frame concerned.

// File: rtl/sci_rx_pkg.sv
// Package: shared constants and types for the serial receiver.
// Assumes an 8-bit register bus and a two-bit register address.
package sci_rx_pkg;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int unsigned CTL_W    = 3;
    localparam int unsigned CTL_EN   = 0;
    localparam int unsigned CTL_NINE = 1;
    localparam int unsigned CTL_IE   = 2;

    localparam int unsigned STAT_R8  = 5;

    // Flag set; the member order gives status bits 4..0.
    typedef struct packed {
        logic framing;
        logic noise;
        logic idle;
        logic overrun;
        logic full;
    } rx_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } deser_state_e;

endpackage

// File: rtl/sci_rx_sync.sv
// Module: sci_rx_sync
// Brings the asynchronous serial line into the clock domain.
// Assumes the idle line level is high, so the stages reset to 1.
module sci_rx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (STAGES < 2) begin : g_single
            logic stage_q;
            // Single flop variant.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= 1'b1;
                else        stage_q <= din;
            end
            assign dout = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            // Shift the line through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
            assign dout = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sci_rx_deser.sv
// Module: sci_rx_deser
// Finds start edges, takes three mid-bit samples per bit, votes by majority
// and shifts the data in least significant bit first. Completes at the middle
// of the stop bit with a one-cycle done pulse.
// Assumes tick_i is a one-cycle pulse at OS times the bit rate, and en_i low
// aborts any frame in progress.
module sci_rx_deser
    import sci_rx_pkg::*;
#(
    parameter int unsigned OS        = 16,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic                 nine_i,
    input  logic                 tick_i,
    input  logic                 line_i,
    output logic                 done_o,
    output logic                 busy_o,
    output logic [DATA_BITS:0]   data_o,
    output logic                 ferr_o,
    output logic                 noise_o
);

    localparam int unsigned DW  = DATA_BITS + 1;
    localparam int unsigned CW  = $clog2(OS);
    localparam int unsigned BIW = $clog2(DW + 1);
    localparam int unsigned MID = OS / 2;
    localparam logic [CW-1:0] S0   = CW'(MID - 1);
    localparam logic [CW-1:0] S1   = CW'(MID);
    localparam logic [CW-1:0] S2   = CW'(MID + 1);
    localparam logic [CW-1:0] LAST = CW'(OS - 1);

    deser_state_e     state;
    logic [CW-1:0]    tcnt;
    logic [BIW-1:0]   bidx;
    logic [1:0]       samp;
    logic [DW-1:0]    shreg;
    logic             nacc;
    logic             line_prev;
    logic             vote;
    logic             vote_noise;
    logic             stop_evt;
    logic [BIW-1:0]   last_bit;

    // Majority of the two stored samples and the live third sample.
    always_comb begin
        vote       = (samp[0] & samp[1]) | (samp[0] & line_i) | (samp[1] & line_i);
        vote_noise = !((samp[0] == samp[1]) && (samp[1] == line_i));
        last_bit   = nine_i ? BIW'(DW - 1) : BIW'(DW - 2);
        stop_evt   = en_i && tick_i && (state == ST_STOP) && (tcnt == S2);
    end

    // Frame state machine, tick counter, sample store and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state     <= ST_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            samp      <= '0;
            shreg     <= '0;
            nacc      <= 1'b0;
            line_prev <= 1'b1;
            done_o    <= 1'b0;
        end else begin
            done_o <= stop_evt;
            if (tick_i) begin
                line_prev <= line_i;
                if (state == ST_IDLE) begin
                    if (line_prev && !line_i) begin
                        state <= ST_START;
                        tcnt  <= CW'(1);
                        nacc  <= 1'b0;
                    end
                end else begin
                    tcnt <= (tcnt == LAST) ? '0 : tcnt + 1'b1;
                    if (tcnt == S0) samp[0] <= line_i;
                    if (tcnt == S1) samp[1] <= line_i;
                    if (tcnt == S2) begin
                        nacc <= nacc | vote_noise;
                        case (state)
                            ST_START: if (vote) state <= ST_IDLE;
                            ST_DATA:  shreg <= {vote, shreg[DW-1:1]};
                            ST_STOP:  state <= ST_IDLE;
                            default:  ;
                        endcase
                    end
                    if (tcnt == LAST) begin
                        case (state)
                            ST_START: begin
                                state <= ST_DATA;
                                bidx  <= '0;
                            end
                            ST_DATA: begin
                                if (bidx == last_bit) state <= ST_STOP;
                                else                  bidx  <= bidx + 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // Hold the finished character and its error indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            ferr_o  <= 1'b0;
            noise_o <= 1'b0;
        end else if (stop_evt) begin
            data_o  <= nine_i ? shreg : {1'b0, shreg[DW-1:1]};
            ferr_o  <= !vote;
            noise_o <= nacc | vote_noise;
        end
    end

    assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/sci_rx_idle.sv
// Module: sci_rx_idle
// Counts ticks of continuous high line while no frame is in progress and
// raises a one-cycle pulse after one full frame time. It is armed by each
// received character and disarmed when it fires.
// Assumes frames of DATA_BITS+2 bits, or DATA_BITS+3 bits in 9-bit mode.
module sci_rx_idle #(
    parameter int unsigned OS        = 16,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic nine_i,
    input  logic tick_i,
    input  logic line_i,
    input  logic busy_i,
    input  logic done_i,
    output logic idle_set_o
);

    localparam int unsigned LIM_S = (DATA_BITS + 2) * OS;
    localparam int unsigned LIM_L = (DATA_BITS + 3) * OS;
    localparam int unsigned TW    = $clog2(LIM_L + 1);

    logic [TW-1:0] cnt;
    logic [TW-1:0] limit;
    logic          armed;

    // Select the frame time for the current mode.
    always_comb limit = nine_i ? TW'(LIM_L - 1) : TW'(LIM_S - 1);

    // High-line tick counter with arm and fire logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            armed      <= 1'b0;
            idle_set_o <= 1'b0;
        end else begin
            idle_set_o <= 1'b0;
            if (done_i) armed <= 1'b1;
            if (!en_i || busy_i || !line_i) begin
                cnt <= '0;
            end else if (tick_i) begin
                if (cnt == limit) begin
                    cnt <= '0;
                    if (armed && !done_i) begin
                        idle_set_o <= 1'b1;
                        armed      <= 1'b0;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sci_rx_status.sv
// Module: sci_rx_status
// Keeps the data register and the five flags, and carries out the clearing
// sequence: a status read records the set flags, and the next data read
// clears only those. A new character discards the record.
// Assumes status and data reads are never in the same cycle.
module sci_rx_status
    import sci_rx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               done_i,
    input  logic [DATA_BITS:0] data_i,
    input  logic               ferr_i,
    input  logic               noise_i,
    input  logic               idle_set_i,
    input  logic               stat_rd_i,
    input  logic               data_rd_i,
    output rx_flags_t          flags_o,
    output rx_flags_t          cap_o,
    output logic [DATA_BITS:0] data_o
);

    rx_flags_t nxt;

    // Next flag value: clear the recorded set, then apply new events.
    always_comb begin
        nxt = flags_o;
        if (data_rd_i) nxt = rx_flags_t'(nxt & ~cap_o);
        if (idle_set_i) nxt.idle = 1'b1;
        if (done_i) begin
            nxt.overrun = nxt.overrun | flags_o.full;
            nxt.full    = 1'b1;
            nxt.noise   = nxt.noise | noise_i;
            nxt.framing = nxt.framing | ferr_i;
        end
    end

    // Flag, record and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_o <= '0;
            cap_o   <= '0;
            data_o  <= '0;
        end else begin
            flags_o <= nxt;
            if (done_i)         cap_o <= '0;
            else if (stat_rd_i) cap_o <= flags_o;
            else if (data_rd_i) cap_o <= '0;
            if (done_i) data_o <= data_i;
        end
    end

endmodule

// File: rtl/sci_rx_core.sv
// Module: sci_rx_core
// Top of the serial receiver. It holds the control register, decodes
// register accesses, and joins the synchronizer, deserializer, idle timer
// and status block.
// Assumes an 8-bit register bus (DATA_BITS = 8) and a tick supplied at
// OS times the bit rate.
module sci_rx_core
    import sci_rx_pkg::*;
#(
    parameter int unsigned OS          = 16,
    parameter int unsigned DATA_BITS   = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_line_i,
    input  logic                 os_tick_i,
    input  logic                 reg_rd_i,
    input  logic                 reg_wr_i,
    input  logic [1:0]           reg_addr_i,
    input  logic [DATA_BITS-1:0] reg_wdata_i,
    output logic [DATA_BITS-1:0] reg_rdata_o,
    output logic                 rx_irq_o
);

    logic [CTL_W-1:0]  ctl_q;
    logic              line_s;
    logic              done;
    logic              busy;
    logic              ferr;
    logic              noise;
    logic              idle_set;
    logic [DATA_BITS:0] deser_data;
    logic [DATA_BITS:0] data_q;
    rx_flags_t         flags;
    rx_flags_t         cap;
    logic              rx_en;
    logic              nine;
    logic              full_ie;
    logic              stat_rd;
    logic              data_rd;
    logic              wr_stat;
    logic              wdata_unused;

    assign rx_en        = ctl_q[CTL_EN];
    assign nine         = ctl_q[CTL_NINE];
    assign full_ie      = ctl_q[CTL_IE];
    assign stat_rd      = reg_rd_i && (reg_addr_i == ADDR_STAT);
    assign data_rd      = reg_rd_i && (reg_addr_i == ADDR_DATA);
    assign wr_stat      = reg_wr_i && (reg_addr_i == ADDR_STAT);
    assign wdata_unused = ^reg_wdata_i[DATA_BITS-1:CTL_W];

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      ctl_q <= '0;
        else if (reg_wr_i && (reg_addr_i == ADDR_CTL))  ctl_q <= reg_wdata_i[CTL_W-1:0];
    end

    sci_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line_i),
        .dout (line_s)
    );

    sci_rx_deser #(.OS(OS), .DATA_BITS(DATA_BITS)) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (rx_en),
        .nine_i (nine),
        .tick_i (os_tick_i),
        .line_i (line_s),
        .done_o (done),
        .busy_o (busy),
        .data_o (deser_data),
        .ferr_o (ferr),
        .noise_o(noise)
    );

    sci_rx_idle #(.OS(OS), .DATA_BITS(DATA_BITS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (rx_en),
        .nine_i    (nine),
        .tick_i    (os_tick_i),
        .line_i    (line_s),
        .busy_i    (busy),
        .done_i    (done),
        .idle_set_o(idle_set)
    );

    sci_rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done),
        .data_i    (deser_data),
        .ferr_i    (ferr),
        .noise_i   (noise),
        .idle_set_i(idle_set),
        .stat_rd_i (stat_rd),
        .data_rd_i (data_rd),
        .flags_o   (flags),
        .cap_o     (cap),
        .data_o    (data_q)
    );

    // Read data multiplexer for the addressed register.
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_CTL:  reg_rdata_o[CTL_W-1:0] = ctl_q;
            ADDR_STAT: begin
                reg_rdata_o[4:0]     = flags;
                reg_rdata_o[STAT_R8] = data_q[DATA_BITS];
            end
            ADDR_DATA: reg_rdata_o = data_q[DATA_BITS-1:0];
            default:   ;
        endcase
    end

    assign rx_irq_o = flags.full & full_ie;

endmodule

// File: rtl/sci_rx_core_chk.sv
// Module: sci_rx_core_chk
// Temporal checks on the receiver, attached to sci_rx_core by bind.
// Assumes flag bit order: 0 full, 1 overrun, 2 idle, 3 noise, 4 framing.
module sci_rx_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       full_ie,
    input logic       wr_stat,
    input logic       data_rd,
    input logic       done,
    input logic       idle_set,
    input logic [4:0] flags,
    input logic [4:0] cap,
    input logic       rx_irq_o
);

    a_r2_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flags[0]);

    a_r4_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(flags[0]));

    a_r8_full_clears_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[0]) |-> $past(data_rd));

    a_r9_done_drops_record: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cap == 5'd0));

    a_r10_read_without_record: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && (cap == 5'd0) && !done && !idle_set) |=> $stable(flags));

    a_r11_disabled_no_char: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !done);

    a_r12_status_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !data_rd && !done && !idle_set) |=> $stable(flags));

    a_r13_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq_o) |-> ($past(done) || $rose(full_ie)));

endmodule

bind sci_rx_core sci_rx_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (rx_en),
    .full_ie (full_ie),
    .wr_stat (wr_stat),
    .data_rd (data_rd),
    .done    (done),
    .idle_set(idle_set),
    .flags   (flags),
    .cap     (cap),
    .rx_irq_o(rx_irq_o)
);

// File: tb/sci_rx_core_bench.sv
`timescale 1ns/1ps
module sci_rx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Fields: [14:11] glitched frame bit (15 = none), [10] stop level,
    // [9] nine-bit mode, [8:0] data.
    localparam logic [14:0] VEC [6] = '{
        {4'd15, 1'b1, 1'b0, 9'h055},
        {4'd3,  1'b1, 1'b0, 9'h0A3},
        {4'd15, 1'b1, 1'b1, 9'h1F0},
        {4'd0,  1'b1, 1'b1, 9'h0C3},
        {4'd15, 1'b0, 1'b0, 9'h07E},
        {4'd10, 1'b0, 1'b1, 9'h181}
    };

    always #2.5 clk = ~clk;

    sci_rx_core u_sci_rx_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_line_i  (rx),
        .os_tick_i  (tick),
        .reg_rd_i   (rd),
        .reg_wr_i   (wr),
        .reg_addr_i (addr),
        .reg_wdata_i(wdata),
        .reg_rdata_o(rdata),
        .rx_irq_o   (irq)
    );

    // Oversampling tick: high on every other clock edge.
    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic idle_clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one frame, 32 clocks per bit; optional 2-clock glitch mid-bit.
    task automatic send_frame(input logic [8:0] d, input logic nine,
                              input logic stopv, input int gbit);
        int nb;
        logic bv;
        nb = nine ? 11 : 10;
        for (int b = 0; b < nb; b++) begin
            if (b == 0)           bv = 1'b0;
            else if (b == nb - 1) bv = stopv;
            else                  bv = d[b-1];
            for (int c = 0; c < 32; c++) begin
                @(negedge clk);
                rx = (gbit == b && (c == 15 || c == 16)) ? ~bv : bv;
            end
        end
        @(negedge clk);
        rx = 1'b1;
        idle_clocks(6);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle_clocks(2);

        // R1: reset state.
        reg_read(2'd0, v); check("R1 ctl", v, 8'h00);
        reg_read(2'd1, v); check("R1 status", v, 8'h00);
        reg_read(2'd2, v); check("R1 data", v, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);

        // R11: receiver disabled ignores the line.
        send_frame(9'h03C, 1'b0, 1'b1, 15);
        reg_read(2'd1, v); check("R11 status", v, 8'h00);
        reg_read(2'd2, v); check("R11 data", v, 8'h00);

        // R14: short low pulse is a false start.
        reg_write(2'd0, 8'h01);
        @(negedge clk); rx = 1'b0;
        idle_clocks(4);
        rx = 1'b1;
        idle_clocks(60);
        reg_read(2'd1, v); check("R14 status", v, 8'h00);

        // Table of frames: R2, R3, R5, R6, R8.
        for (int i = 0; i < 6; i++) begin
            logic [8:0] d;
            logic nine, stopv;
            int g;
            logic [7:0] es;
            d = VEC[i][8:0]; nine = VEC[i][9]; stopv = VEC[i][10]; g = int'(VEC[i][14:11]);
            es = 8'h01 | ((g != 15) ? 8'h08 : 8'h00) | (!stopv ? 8'h10 : 8'h00)
                 | ((nine && d[8]) ? 8'h20 : 8'h00);
            reg_write(2'd0, {6'd0, nine, 1'b1});
            send_frame(d, nine, stopv, g);
            reg_read(2'd1, v); check("R2/R3/R5/R6 status", v, es);
            reg_read(2'd2, v); check("R2 data", v, d[7:0]);
            reg_read(2'd1, v); check("R8 cleared", v, es & 8'h20);
        end

        // R4: overrun keeps the newest character.
        reg_write(2'd0, 8'h01);
        send_frame(9'h011, 1'b0, 1'b1, 15);
        send_frame(9'h022, 1'b0, 1'b1, 15);
        reg_read(2'd1, v); check("R4 status", v, 8'h03);
        reg_read(2'd2, v); check("R4 data", v, 8'h22);
        reg_read(2'd1, v); check("R4 cleared", v, 8'h00);

        // R9: character between status and data read voids the record.
        send_frame(9'h033, 1'b0, 1'b1, 15);
        reg_read(2'd1, v); check("R9 first status", v, 8'h01);
        send_frame(9'h044, 1'b0, 1'b1, 15);
        reg_read(2'd2, v); check("R9 data", v, 8'h44);
        reg_read(2'd1, v); check("R9 flags kept", v, 8'h03);
        reg_read(2'd2, v);
        reg_read(2'd1, v); check("R9 cleared", v, 8'h00);

        // R10: data read with no record clears nothing.
        send_frame(9'h055, 1'b0, 1'b1, 15);
        reg_read(2'd2, v); check("R10 data", v, 8'h55);
        reg_read(2'd1, v); check("R10 flags kept", v, 8'h01);
        reg_read(2'd2, v);

        // R12: writes to status and data are ignored.
        send_frame(9'h066, 1'b0, 1'b1, 15);
        reg_write(2'd1, 8'h00);
        reg_write(2'd1, 8'hFF);
        reg_write(2'd2, 8'h99);
        reg_read(2'd1, v); check("R12 status", v, 8'h01);
        reg_read(2'd2, v); check("R12 data", v, 8'h66);
        reg_read(2'd1, v); check("R12 cleared", v, 8'h00);

        // R13: interrupt follows full and its enable.
        reg_write(2'd0, 8'h05);
        send_frame(9'h077, 1'b0, 1'b1, 15);
        check("R13 irq set", {7'd0, irq}, 8'h01);
        reg_read(2'd1, v);
        reg_read(2'd2, v);
        check("R13 irq cleared", {7'd0, irq}, 8'h00);
        reg_write(2'd0, 8'h01);
        send_frame(9'h078, 1'b0, 1'b1, 15);
        check("R13 irq masked", {7'd0, irq}, 8'h00);
        reg_read(2'd1, v); check("R13 status", v, 8'h01);
        reg_read(2'd2, v);

        // R7: idle flag once per character.
        send_frame(9'h05A, 1'b0, 1'b1, 15);
        reg_read(2'd1, v); check("R7 pre status", v, 8'h01);
        reg_read(2'd2, v);
        idle_clocks(400);
        reg_read(2'd1, v); check("R7 idle set", v, 8'h04);
        reg_read(2'd2, v);
        idle_clocks(400);
        reg_read(2'd1, v); check("R7 idle once", v, 8'h00);

        finished = 1;
        summary();
        $finish;
    end

endmodule